// File: doc/BRIEF.md
# Program/Erase Verify-Retry Sequencer

This block drives one erase or program operation on a memory page. It does not use a fixed timing budget. It alternates between a pulse phase, which strobes the array to erase or program, and a verify phase, which asks the array whether every cell has reached its target state. When the array reports a miss, the sequencer applies another pulse of the same kind and verifies again. The total length of an operation therefore depends on how the cells respond.

The only way the outside world learns that an operation has finished is the ready/busy indication. It is shown in two places: bit 7 of an 8-bit status word and a dedicated output pin. A configurable ceiling on the number of pulses keeps the loop from running forever. When that ceiling is reached without a pass, the operation ends and sets a fail bit (bit 0 of the status word). That bit stays set until the next operation is accepted.

Top module: `pvs_top`

## Requirements
- R1: After reset the block is ready: `readyPin` is 1, `statusReg` is 8'h80 and all three phase strobes are 0.
- R2: A `startReq` seen while ready is accepted: from the next cycle `readyPin` and `statusReg[7]` read 0 (busy).
- R3: Each pulse phase lasts exactly PULSE_CYCLES cycles and asserts `progPulse` when `startOp` was 1 at acceptance, or `erasePulse` when it was 0, never the other. It is followed at once by exactly VERIFY_CYCLES cycles of `verifyStrobe`. At most one of the three strobes is high in any cycle.
- R4: `verifyPass` is sampled in the last verify cycle. When it is 0 and the pulse ceiling is not reached, another pulse phase begins in the next cycle.
- R5: When the N-th verify passes (N ≤ MAX_PULSES), the block is busy for exactly N·(PULSE_CYCLES+VERIFY_CYCLES) cycles, then reads ready with the fail bit 0.
- R6: A `startReq` received while busy is ignored: the operation type, the pulse count and the busy length are unchanged.
- R7: When the verify after pulse MAX_PULSES fails, the operation ends after MAX_PULSES·(PULSE_CYCLES+VERIFY_CYCLES) busy cycles, with `statusReg[0]` = 1.
- R8: The fail bit holds while the block is ready and idle, and reads 0 from the first busy cycle of the next accepted operation.
- R9: `statusReg[7]` always equals `readyPin`, and `statusReg[6:1]` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin an operation |
| startOp | input | 1 | Operation type with the request: 1 program, 0 erase |
| verifyPass | input | 1 | Array verify result, sampled in the last verify cycle |
| erasePulse | output | 1 | Erase pulse strobe |
| progPulse | output | 1 | Program pulse strobe |
| verifyStrobe | output | 1 | Verify phase strobe |
| statusReg | output | 8 | Status word: bit 7 ready, bit 0 fail, others 0 |
| readyPin | output | 1 | Ready/busy pin: 1 ready, 0 busy |

## Verification
The bench builds the block with PULSE_CYCLES=3, VERIFY_CYCLES=2 and MAX_PULSES=4. At these values every number of pulses needed, from one up to one beyond the ceiling, can be swept for both operation types, and each busy length stays short. A small array model in the bench counts pulses and reports a pass once its chosen target is met. Busy length, pulse count, strobe widths and the fail bit are all predicted arithmetically. The ceiling case, back-to-back starts issued in the done cycle, and stray starts while busy are all within a few dozen cycles.

// File: rtl/pvs_pkg.sv
package pvs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_VERIFY = 2'd2,
    ST_DONE   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadOp;
    logic firstPulse;
    logic incPulse;
    logic loadPulseTimer;
    logic loadVerifyTimer;
    logic setFail;
    logic clearFail;
  } ctrlStrobes_t;

endpackage

// File: rtl/pvs_dpath.sv
module pvs_dpath
  import pvs_pkg::*;
#(
  parameter int PULSE_CYCLES  = 8,
  parameter int VERIFY_CYCLES = 4,
  parameter int MAX_PULSES    = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic         startOp,
  input  logic         ready,
  output logic         opIsProg,
  output logic         phaseDone,
  output logic         atLimit,
  output logic [7:0]   statusReg
);

  localparam int LONGEST = (PULSE_CYCLES > VERIFY_CYCLES) ? PULSE_CYCLES : VERIFY_CYCLES;
  localparam int TMR_W   = $clog2(LONGEST + 1);
  localparam int CNT_W   = $clog2(MAX_PULSES + 1);
  localparam logic [TMR_W-1:0] PULSE_LOAD  = TMR_W'(PULSE_CYCLES - 1);
  localparam logic [TMR_W-1:0] VERIFY_LOAD = TMR_W'(VERIFY_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX     = CNT_W'(MAX_PULSES);

  logic [TMR_W-1:0] phaseTimer;
  logic [CNT_W-1:0] pulseCnt;
  logic             failFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseTimer <= '0;
    end else if (strb.loadPulseTimer) begin
      phaseTimer <= PULSE_LOAD;
    end else if (strb.loadVerifyTimer) begin
      phaseTimer <= VERIFY_LOAD;
    end else if (phaseTimer != '0) begin
      phaseTimer <= phaseTimer - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strb.firstPulse) begin
      pulseCnt <= CNT_W'(1);
    end else if (strb.incPulse) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opIsProg <= 1'b0;
    end else if (strb.loadOp) begin
      opIsProg <= startOp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failFlag <= 1'b0;
    end else if (strb.clearFail) begin
      failFlag <= 1'b0;
    end else if (strb.setFail) begin
      failFlag <= 1'b1;
    end
  end

  assign phaseDone = (phaseTimer == '0);
  assign atLimit   = (pulseCnt == CNT_MAX);
  assign statusReg = {ready, 6'b000000, failFlag};

  // R7: the pulse counter never passes the ceiling
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CNT_MAX);

  // R7: a fail is only raised with the ceiling reached
  a_r7_fail_at_limit: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFail |-> atLimit);

  // R8: the fail bit is sticky until cleared by a new start
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !strb.clearFail) |=> failFlag);

  // R8: a new start clears the fail bit
  a_r8_fail_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearFail |=> !statusReg[0]);

endmodule

// File: rtl/pvs_ctrl.sv
module pvs_ctrl
  import pvs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         verifyPass,
  input  logic         opIsProg,
  input  logic         phaseDone,
  input  logic         atLimit,
  output ctrlStrobes_t strb,
  output logic         ready,
  output logic         erasePulse,
  output logic         progPulse,
  output logic         verifyStrobe
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (startReq) begin
          stateNext           = ST_PULSE;
          strb.loadOp         = 1'b1;
          strb.firstPulse     = 1'b1;
          strb.clearFail      = 1'b1;
          strb.loadPulseTimer = 1'b1;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_PULSE: begin
        if (phaseDone) begin
          stateNext            = ST_VERIFY;
          strb.loadVerifyTimer = 1'b1;
        end
      end
      ST_VERIFY: begin
        if (phaseDone) begin
          if (verifyPass) begin
            stateNext = ST_DONE;
          end else if (atLimit) begin
            stateNext    = ST_DONE;
            strb.setFail = 1'b1;
          end else begin
            stateNext           = ST_PULSE;
            strb.incPulse       = 1'b1;
            strb.loadPulseTimer = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign ready        = (state == ST_IDLE) || (state == ST_DONE);
  assign erasePulse   = (state == ST_PULSE) && !opIsProg;
  assign progPulse    = (state == ST_PULSE) && opIsProg;
  assign verifyStrobe = (state == ST_VERIFY);

  // R3: at most one phase strobe is active
  a_r3_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({erasePulse, progPulse, verifyStrobe}));

  // R3: verify follows a pulse phase directly
  a_r3_verify_follows: assert property (@(posedge clk) disable iff (!rstN)
    $fell(erasePulse || progPulse) |-> verifyStrobe);

  // R2: an accepted start makes the block busy in the next cycle
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (ready && startReq) |=> !ready);

  // R6: a start while busy leaves the operation type untouched
  a_r6_op_held: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && startReq) |=> $stable(opIsProg));

endmodule

// File: rtl/pvs_top.sv
module pvs_top
  import pvs_pkg::*;
#(
  parameter int PULSE_CYCLES  = 8,
  parameter int VERIFY_CYCLES = 4,
  parameter int MAX_PULSES    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       startOp,
  input  logic       verifyPass,
  output logic       erasePulse,
  output logic       progPulse,
  output logic       verifyStrobe,
  output logic [7:0] statusReg,
  output logic       readyPin
);

  ctrlStrobes_t strb;
  logic         ready;
  logic         opIsProg;
  logic         phaseDone;
  logic         atLimit;

  pvs_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .verifyPass   (verifyPass),
    .opIsProg     (opIsProg),
    .phaseDone    (phaseDone),
    .atLimit      (atLimit),
    .strb         (strb),
    .ready        (ready),
    .erasePulse   (erasePulse),
    .progPulse    (progPulse),
    .verifyStrobe (verifyStrobe)
  );

  pvs_dpath #(
    .PULSE_CYCLES  (PULSE_CYCLES),
    .VERIFY_CYCLES (VERIFY_CYCLES),
    .MAX_PULSES    (MAX_PULSES)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .startOp   (startOp),
    .ready     (ready),
    .opIsProg  (opIsProg),
    .phaseDone (phaseDone),
    .atLimit   (atLimit),
    .statusReg (statusReg)
  );

  assign readyPin = ready;

  // R9: pin and status bit agree, reserved bits stay low
  a_r9_pin_matches: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg[7] == readyPin) && (statusReg[6:1] == 6'b0));

endmodule

// File: tb/test_pvs_top.sv
module test_pvs_top;

  localparam int P   = 3;
  localparam int V   = 2;
  localparam int MAXP = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       startOp = 1'b0;
  logic       verifyPass = 1'b0;
  logic       erasePulse, progPulse, verifyStrobe, readyPin;
  logic [7:0] statusReg;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pvs_top #(
    .PULSE_CYCLES  (P),
    .VERIFY_CYCLES (V),
    .MAX_PULSES    (MAXP)
  ) i_pvs_top (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .startOp      (startOp),
    .verifyPass   (verifyPass),
    .erasePulse   (erasePulse),
    .progPulse    (progPulse),
    .verifyStrobe (verifyStrobe),
    .statusReg    (statusReg),
    .readyPin     (readyPin)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Array model: passes once 'target' pulses have been applied
  task automatic runOp(input logic op, input int target, input bit poke);
    int pulses = 0;
    int busy = 0;
    int pulseCyc = 0;
    int verCyc = 0;
    int wrongOp = 0;
    int failSeen = 0;
    int mism = 0;
    int expN;
    logic prevP = 1'b0;
    logic curP;
    expN = (target > MAXP) ? MAXP : target;
    startReq = 1'b1;
    startOp = op;
    verifyPass = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
    chk(readyPin == 1'b0 && statusReg[7] == 1'b0, "R2 busy after start", int'(readyPin), 0);
    while (!readyPin && busy < 2000) begin
      busy++;
      curP = op ? progPulse : erasePulse;
      if (op ? erasePulse : progPulse) wrongOp++;
      if (curP) pulseCyc++;
      if (verifyStrobe) verCyc++;
      if (curP && !prevP) pulses++;
      prevP = curP;
      if (statusReg[7] !== readyPin || statusReg[6:1] != 6'b0) mism++;
      if (statusReg[0]) failSeen++;
      if (poke && (busy == 2 || busy == P + V + 1)) begin
        startReq = 1'b1;
        startOp = !op;
      end else begin
        startReq = 1'b0;
      end
      verifyPass = (pulses >= target);
      @(negedge clk);
    end
    startReq = 1'b0;
    chk(busy == expN * (P + V), target > MAXP ? "R7 busy length" : "R5 busy length", busy, expN * (P + V));
    chk(pulses == expN, "R4 pulse count", pulses, expN);
    chk(pulseCyc == expN * P, "R3 pulse cycles", pulseCyc, expN * P);
    chk(verCyc == expN * V, "R3 verify cycles", verCyc, expN * V);
    chk(wrongOp == 0, poke ? "R6 stray start op" : "R3 op select", wrongOp, 0);
    chk(failSeen == 0, "R8 fail cleared while busy", failSeen, 0);
    chk(mism == 0, "R9 status/pin agree", mism, 0);
    chk(statusReg[0] == (target > MAXP), target > MAXP ? "R7 fail bit" : "R5 fail bit",
        int'(statusReg[0]), int'(target > MAXP));
    chk(statusReg[7] == 1'b1, "R5 ready at end", int'(statusReg[7]), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(readyPin == 1'b1, "R1 ready pin", int'(readyPin), 1);
    chk(statusReg == 8'h80, "R1 status", int'(statusReg), 8'h80);
    chk({erasePulse, progPulse, verifyStrobe} == 3'b000, "R1 strobes",
        int'({erasePulse, progPulse, verifyStrobe}), 0);

    for (int op = 0; op < 2; op++) begin
      for (int t = 1; t <= MAXP + 1; t++) begin
        runOp(op[0], t, 1'b0);
      end
    end

    // R8: fail bit holds while idle
    runOp(1'b0, MAXP + 1, 1'b0);
    repeat (5) @(negedge clk);
    chk(statusReg == 8'h81, "R8 fail sticky idle", int'(statusReg), 8'h81);

    // R6: stray starts during busy, then a clean run clears fail
    runOp(1'b1, 3, 1'b1);
    runOp(1'b0, 2, 1'b1);
    runOp(1'b1, MAXP + 1, 1'b1);
    repeat (2) @(negedge clk);
    runOp(1'b0, 1, 1'b0);
    chk(statusReg == 8'h80, "R8 fail cleared after run", int'(statusReg), 8'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule